// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one channel of an event timer. It watches a free-running 64-bit main counter that another block supplies. When that counter reaches the value held in the channel's comparator, the channel raises a one-cycle fire pulse. Software sets up the channel with 32-bit word writes from the register core. Those writes reach three registers: a configuration register, a comparator split into low and high words, and a route register that is kept only so its addresses decode.

In one-shot mode the channel fires once and then stays quiet until the comparator is moved ahead of the counter. In periodic mode a hidden period register is loaded alongside the comparator. After each match the comparator steps forward by that period, one step per clock, until it is ahead of the counter again. A narrow mode limits the comparison, the comparator and the period to 32 bits. In narrow one-shot mode the channel also produces a wrap pulse when the low 32 bits of the counter roll over before the match. A set-value flag lets software move the comparator without disturbing the period, and the channel clears that flag by itself. The enable, level and route fields are passed out to the interrupt block.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the configuration word (index 0) reads 0x00000030, with the periodic-capable bit 4 and the 64-bit-capable bit 5 set. Index 1 reads 0xFFFFFFFF. Both comparator words (index 2 low, index 3 high) read 0xFFFFFFFF. The period is zero. No fire pulse occurs while the counter stays at zero.
- R2: A configuration write keeps only level (bit 1), enable (bit 2), periodic (bit 3), set-value (bit 6), narrow mode (bit 8) and route (bits 13:9). Every other bit reads back with its fixed value. Writes to index 1, index 4 and index 5 have no effect, and indices 4 and 5 read zero.
- R3: A configuration write with bit 8 set clears the upper 32 bits of both the comparator and the period. While narrow mode is active, writes to the comparator high word are ignored and the high word stays zero.
- R4: In periodic mode with set-value clear, a comparator word write also loads the same half of the period. On a low-word write in narrow mode, bit 31 of the value is cleared first, so the comparator and the period both take the cleared value.
- R5: With set-value set, a comparator write changes only the comparator. Set-value then clears itself: after a low-word write in narrow mode, or after a high-word write in 64-bit mode. A 64-bit low-word write leaves set-value set.
- R6: The comparator counts as reached when (comparator − counter) is zero or negative as a signed value, over 32 bits in narrow mode and over 64 bits otherwise. fire_o rises for exactly one cycle, one clock after the first edge at which the reached condition turns true.
- R7: In periodic mode with a nonzero period, while the comparator is reached it advances by the period once per clock until it is ahead of the counter. In narrow mode the sum wraps at 32 bits.
- R8: In narrow one-shot mode, wrap_o pulses for one cycle, one clock after bit 31 of the counter falls from 1 to 0 while the match is still pending. No wrap pulse occurs in 64-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_idx | input | 3 | Word index of the write (0 cfg lo, 1 cfg hi, 2 cmp lo, 3 cmp hi, 4/5 route) |
| wr_data | input | 32 | Write data |
| rd_idx | input | 3 | Word index of the combinational read |
| rd_data | output | 32 | Read data for rd_idx |
| count_i | input | 64 | Shared main counter |
| fire_o | output | 1 | One-cycle comparator match pulse |
| wrap_o | output | 1 | One-cycle narrow one-shot wrap pulse |
| cfg_enable_o | output | 1 | Enable field, passed to the interrupt block |
| cfg_level_o | output | 1 | Interrupt type field (1 = level) |
| cfg_route_o | output | 5 | Route field |

## Verification
A wrong comparator or configuration value shows on rd_data in the same cycle it is read back, one cycle after the write that caused it. A stale or wrongly truncated period is hidden from reads. It only shows as a wrong comparator value, which appears on the cycle after the first match and settles once the advance finishes, a number of cycles equal to the count of period steps needed. A faulty reached decision or edge tracker shows on fire_o one clock after the counter crosses the comparator, either as a missing pulse, a pulse that lasts longer than one cycle, or a pulse that repeats.

// File: rtl/evt_ch_pkg.sv
package evt_ch_pkg;
    localparam int IDX_W      = 3;
    localparam int ROUTE_W    = 5;
    localparam int LEVEL_BIT  = 1;
    localparam int ENABLE_BIT = 2;
    localparam int PERIOD_BIT = 3;
    localparam int PCAP_BIT   = 4;
    localparam int WCAP_BIT   = 5;
    localparam int SETVAL_BIT = 6;
    localparam int NARROW_BIT = 8;
    localparam int ROUTE_LSB  = 9;
    localparam int CFG_USED_W = ROUTE_LSB + ROUTE_W;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               narrow;
        logic               setval;
        logic               periodic;
        logic               enable;
        logic               level;
    } cfg_t;

    typedef enum logic [IDX_W-1:0] {
        SLOT_CFG_LO = 3'd0,
        SLOT_CFG_HI = 3'd1,
        SLOT_CMP_LO = 3'd2,
        SLOT_CMP_HI = 3'd3,
        SLOT_RT_LO  = 3'd4,
        SLOT_RT_HI  = 3'd5,
        SLOT_RSV6   = 3'd6,
        SLOT_RSV7   = 3'd7
    } slot_e;

    function automatic cfg_t cfg_from_word(input logic [CFG_USED_W-1:0] w);
        cfg_t c;
        c.level    = w[LEVEL_BIT];
        c.enable   = w[ENABLE_BIT];
        c.periodic = w[PERIOD_BIT];
        c.setval   = w[SETVAL_BIT];
        c.narrow   = w[NARROW_BIT];
        c.route    = w[ROUTE_LSB +: ROUTE_W];
        return c;
    endfunction

    function automatic logic [CFG_USED_W-1:0] cfg_to_word(input cfg_t c);
        logic [CFG_USED_W-1:0] w;
        w = '0;
        w[LEVEL_BIT]            = c.level;
        w[ENABLE_BIT]           = c.enable;
        w[PERIOD_BIT]           = c.periodic;
        w[PCAP_BIT]             = 1'b1;
        w[WCAP_BIT]             = 1'b1;
        w[SETVAL_BIT]           = c.setval;
        w[NARROW_BIT]           = c.narrow;
        w[ROUTE_LSB +: ROUTE_W] = c.route;
        return w;
    endfunction
endpackage

// File: rtl/evt_ch_cmp.sv
module evt_ch_cmp #(
    parameter  int DW = 32,
    localparam int CW = 2 * DW
) (
    input  logic [CW-1:0] cmp_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          narrow_i,
    output logic          reached_o
);
    logic [CW-1:0] diff_w;
    logic [DW-1:0] diff_n;
    logic          hit_w;
    logic          hit_n;

    always_comb begin
        diff_w    = cmp_i - cnt_i;
        diff_n    = cmp_i[DW-1:0] - cnt_i[DW-1:0];
        hit_w     = diff_w[CW-1] || (diff_w == '0);
        hit_n     = diff_n[DW-1] || (diff_n == '0);
        reached_o = narrow_i ? hit_n : hit_w;
    end
endmodule

// File: rtl/evt_ch_regs.sv
module evt_ch_regs
    import evt_ch_pkg::*;
#(
    parameter  int DW = 32,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  slot_e         wr_slot,
    input  logic [DW-1:0] wr_data,
    input  logic          reached,
    output cfg_t          cfg_o,
    output logic [CW-1:0] cmp_o,
    output logic [CW-1:0] per_o
);
    typedef struct packed {
        cfg_t          cfg;
        logic [CW-1:0] cmp;
        logic [CW-1:0] per;
    } st_t;

    st_t           st_d;
    st_t           st_q;
    logic [CW-1:0] sum_w;
    logic [DW-1:0] lo_v;

    always_comb begin
        st_d  = st_q;
        sum_w = st_q.cmp + st_q.per;
        lo_v  = wr_data;

        if (st_q.cfg.periodic && (st_q.per != '0) && reached) begin
            st_d.cmp = st_q.cfg.narrow ? {{DW{1'b0}}, sum_w[DW-1:0]} : sum_w;
        end

        if (wr_en) begin
            case (wr_slot)
                SLOT_CFG_LO: begin
                    st_d.cfg = cfg_from_word(wr_data[CFG_USED_W-1:0]);
                    if (wr_data[NARROW_BIT]) begin
                        st_d.cmp = {{DW{1'b0}}, st_q.cmp[DW-1:0]};
                        st_d.per = {{DW{1'b0}}, st_q.per[DW-1:0]};
                    end
                end
                SLOT_CMP_LO: begin
                    if (st_q.cfg.setval) begin
                        if (st_q.cfg.narrow) begin
                            st_d.cfg.setval = 1'b0;
                        end
                    end else if (st_q.cfg.periodic) begin
                        if (st_q.cfg.narrow) begin
                            lo_v[DW-1] = 1'b0;
                        end
                        st_d.per = {st_q.per[CW-1:DW], lo_v};
                    end
                    st_d.cmp = {st_q.cmp[CW-1:DW], lo_v};
                end
                SLOT_CMP_HI: begin
                    if (!st_q.cfg.narrow) begin
                        if (st_q.cfg.setval) begin
                            st_d.cfg.setval = 1'b0;
                        end else if (st_q.cfg.periodic) begin
                            st_d.per = {wr_data, st_q.per[DW-1:0]};
                        end
                        st_d.cmp = {wr_data, st_q.cmp[DW-1:0]};
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg <= '0;
            st_q.cmp <= '1;
            st_q.per <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
    assign cmp_o = st_q.cmp;
    assign per_o = st_q.per;
endmodule

// File: rtl/evt_ch_evt.sv
module evt_ch_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic reached,
    input  logic oneshot_narrow,
    input  logic cnt_msb,
    output logic fire_o,
    output logic wrap_o
);
    typedef struct packed {
        logic seen;
        logic msb;
        logic fire;
        logic wrap;
    } ev_t;

    ev_t ev_d;
    ev_t ev_q;

    always_comb begin
        ev_d      = ev_q;
        ev_d.seen = reached;
        ev_d.msb  = cnt_msb;
        ev_d.fire = reached && !ev_q.seen;
        ev_d.wrap = oneshot_narrow && !ev_q.seen && ev_q.msb && !cnt_msb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q.seen <= 1'b1;
            ev_q.msb  <= 1'b0;
            ev_q.fire <= 1'b0;
            ev_q.wrap <= 1'b0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign fire_o = ev_q.fire;
    assign wrap_o = ev_q.wrap;
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_ch_pkg::*;
#(
    parameter  int DW = 32,
    localparam int CW = 2 * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DW-1:0]      rd_data,
    input  logic [CW-1:0]      count_i,
    output logic               fire_o,
    output logic               wrap_o,
    output logic               cfg_enable_o,
    output logic               cfg_level_o,
    output logic [ROUTE_W-1:0] cfg_route_o
);
    cfg_t          cfg_q;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] per_q;
    logic          reached;

    evt_ch_regs #(.DW(DW)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (slot_e'(wr_idx)),
        .wr_data (wr_data),
        .reached (reached),
        .cfg_o   (cfg_q),
        .cmp_o   (cmp_q),
        .per_o   (per_q)
    );

    evt_ch_cmp #(.DW(DW)) cmp_i (
        .cmp_i     (cmp_q),
        .cnt_i     (count_i),
        .narrow_i  (cfg_q.narrow),
        .reached_o (reached)
    );

    evt_ch_evt evt_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .reached        (reached),
        .oneshot_narrow (cfg_q.narrow && !cfg_q.periodic),
        .cnt_msb        (count_i[DW-1]),
        .fire_o         (fire_o),
        .wrap_o         (wrap_o)
    );

    always_comb begin
        case (slot_e'(rd_idx))
            SLOT_CFG_LO: rd_data = {{(DW-CFG_USED_W){1'b0}}, cfg_to_word(cfg_q)};
            SLOT_CFG_HI: rd_data = '1;
            SLOT_CMP_LO: rd_data = cmp_q[DW-1:0];
            SLOT_CMP_HI: rd_data = cmp_q[CW-1:DW];
            default:     rd_data = '0;
        endcase
    end

    assign cfg_enable_o = cfg_q.enable;
    assign cfg_level_o  = cfg_q.level;
    assign cfg_route_o  = cfg_q.route;
endmodule

// File: rtl/evt_ch_chk.sv
module evt_ch_chk
    import evt_ch_pkg::*;
#(
    parameter  int DW = 32,
    localparam int CW = 2 * DW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             fire_o,
    input logic             wrap_o,
    input cfg_t             cfg_q,
    input logic [CW-1:0]    cmp_q,
    input logic [CW-1:0]    per_q,
    input logic             reached
);
    p_fire_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    p_narrow_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.narrow |-> (cmp_q[CW-1:DW] == '0));

    p_dead_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == 3'd1 || wr_idx == 3'd4 || wr_idx == 3'd5)) |=> $stable(cfg_q));

    p_setval_hi_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 3'd3 && cfg_q.setval && !cfg_q.narrow) |=> !cfg_q.setval);

    p_setval_keeps_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == 3'd2 || wr_idx == 3'd3) && cfg_q.setval) |=> $stable(per_q));

    p_wide_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cfg_q.periodic && !cfg_q.narrow && per_q != '0 && reached)
        |=> (cmp_q == $past(cmp_q + per_q)));

    p_wrap_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> $past(cfg_q.narrow && !cfg_q.periodic));
endmodule

bind evt_cmp_channel evt_ch_chk #(.DW(DW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .fire_o  (fire_o),
    .wrap_o  (wrap_o),
    .cfg_q   (cfg_q),
    .cmp_q   (cmp_q),
    .per_q   (per_q),
    .reached (reached)
);

// File: tb/evt_cmp_channel_tb_top.sv
module evt_cmp_channel_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [63:0] count = '0;
    logic        fire_o;
    logic        wrap_o;
    logic        en_o;
    logic        lvl_o;
    logic [4:0]  route_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_cmp_channel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .count_i(count), .fire_o(fire_o),
        .wrap_o(wrap_o), .cfg_enable_o(en_o), .cfg_level_o(lvl_o), .cfg_route_o(route_o)
    );

    function automatic bit reached_fn(input logic [63:0] c, input logic [63:0] n, input bit m32);
        logic [63:0] d;
        logic [31:0] d32;
        d   = c - n;
        d32 = c[31:0] - n[31:0];
        if (m32) return d32[31] || (d32 == 32'h0);
        return d[63] || (d == 64'h0);
    endfunction

    function automatic logic [63:0] adv_fn(input logic [63:0] c, input logic [63:0] p,
                                           input logic [63:0] n, input bit m32);
        logic [63:0] r;
        r = c;
        for (int i = 0; i < 10000; i++) begin
            if (!reached_fn(r, n, m32)) break;
            r = m32 ? {32'h0, r[31:0] + p[31:0]} : r + p;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] idx, input logic [31:0] exp, input string req);
        rd_idx = idx;
        #1;
        chk(rd_data == exp, req, {32'h0, rd_data}, {32'h0, exp});
    endtask

    task automatic set_cnt(input logic [63:0] v);
        count = v;
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] exp_c;
        int pulses;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(3'd0, 32'h30, "R1 cfg lo");
        rd_chk(3'd1, 32'hFFFFFFFF, "R1 cfg hi");
        rd_chk(3'd2, 32'hFFFFFFFF, "R1 cmp lo");
        rd_chk(3'd3, 32'hFFFFFFFF, "R1 cmp hi");
        pulses = 0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); pulses += int'(fire_o) + int'(wrap_o); end
        chk(pulses == 0, "R1 quiet after reset", 64'(pulses), 64'd0);

        // R2 mask and dead slots
        wr(3'd0, 32'h00000204);
        rd_chk(3'd0, 32'h234, "R2 cfg route+enable");
        chk(en_o == 1'b1 && route_o == 5'd1, "R2 field outputs", {59'h0, route_o}, 64'h1);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'hFFFFFFFF);
        wr(3'd5, 32'hFFFFFFFF);
        rd_chk(3'd0, 32'h234, "R2 cfg unchanged by dead writes");
        rd_chk(3'd1, 32'hFFFFFFFF, "R2 cfg hi fixed");
        rd_chk(3'd4, 32'h0, "R2 route lo reads zero");
        rd_chk(3'd5, 32'h0, "R2 route hi reads zero");
        rd_chk(3'd2, 32'hFFFFFFFF, "R2 cmp untouched");
        wr(3'd0, 32'hFFFFFFFF);
        rd_chk(3'd0, 32'h3F7E, "R2 write mask");
        chk(lvl_o == 1'b1 && route_o == 5'h1F, "R2 level and route", {59'h0, route_o}, 64'h1F);

        // R3 narrow truncation
        rd_chk(3'd2, 32'hFFFFFFFF, "R3 cmp lo kept");
        rd_chk(3'd3, 32'h0, "R3 cmp hi truncated");
        wr(3'd3, 32'h12345678);
        rd_chk(3'd3, 32'h0, "R3 hi write ignored in narrow");
        wr(3'd0, 32'h0);
        rd_chk(3'd0, 32'h30, "R2 cfg cleared");

        // R4 / R6 / R7 periodic 64-bit
        wr(3'd0, 32'h08);
        wr(3'd3, 32'h0);
        wr(3'd2, 32'd100);
        rd_chk(3'd2, 32'd100, "R4 cmp lo periodic");
        set_cnt(64'd99);
        chk(fire_o == 1'b0, "R6 no fire before match", 64'(fire_o), 64'd0);
        set_cnt(64'd100);
        chk(fire_o == 1'b1, "R6 fire at match", 64'(fire_o), 64'd1);
        rd_chk(3'd2, 32'd200, "R7 one period step");
        @(negedge clk);
        chk(fire_o == 1'b0, "R6 pulse one cycle", 64'(fire_o), 64'd0);
        count = 64'd1000;
        pulses = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); pulses += int'(fire_o); end
        chk(pulses == 1, "R6 single pulse during advance", 64'(pulses), 64'd1);
        exp_c = adv_fn(64'd200, 64'd100, 64'd1000, 1'b0);
        rd_chk(3'd2, exp_c[31:0], "R7 multi-step advance");

        // R5 set-value in 64-bit mode
        set_cnt(64'd0);
        wr(3'd0, 32'h48);
        wr(3'd2, 32'h500);
        rd_chk(3'd0, 32'h78, "R5 setval kept after wide lo write");
        wr(3'd3, 32'h0);
        rd_chk(3'd0, 32'h38, "R5 setval cleared after hi write");
        rd_chk(3'd2, 32'h500, "R5 cmp loaded");
        set_cnt(64'h500);
        chk(fire_o == 1'b1, "R6 fire after setval load", 64'(fire_o), 64'd1);
        rd_chk(3'd2, 32'h500 + 32'd100, "R5 period untouched");

        // R4 / R7 narrow periodic
        set_cnt(64'd0);
        wr(3'd0, 32'h108);
        wr(3'd2, 32'h80000010);
        rd_chk(3'd2, 32'h10, "R4 bit31 cleared in narrow");
        count = {32'hA5A5_0000, 32'h20};
        repeat (4) @(negedge clk);
        exp_c = adv_fn(64'h10, 64'h10, {32'hA5A5_0000, 32'h20}, 1'b1);
        rd_chk(3'd2, exp_c[31:0], "R7 narrow advance");
        set_cnt(64'hFFFFFFE0);
        wr(3'd0, 32'h148);
        wr(3'd2, 32'hFFFFFFF0);
        rd_chk(3'd0, 32'h138, "R5 setval cleared by narrow lo write");
        rd_chk(3'd2, 32'hFFFFFFF0, "R5 cmp loaded narrow");
        set_cnt(64'hFFFFFFF8);
        chk(fire_o == 1'b1, "R6 narrow fire", 64'(fire_o), 64'd1);
        @(negedge clk);
        rd_chk(3'd2, 32'h0, "R7 narrow sum wraps");
        rd_chk(3'd3, 32'h0, "R7 narrow hi stays zero");

        // R8 narrow one-shot wrap
        wr(3'd0, 32'h100);
        wr(3'd2, 32'h10);
        set_cnt(64'hFFFFFFF0);
        chk(wrap_o == 1'b0 && fire_o == 1'b0, "R8 no event before wrap", 64'(wrap_o), 64'd0);
        set_cnt(64'h1_00000005);
        chk(wrap_o == 1'b1, "R8 wrap pulse", 64'(wrap_o), 64'd1);
        chk(fire_o == 1'b0, "R8 no fire at wrap", 64'(fire_o), 64'd0);
        @(negedge clk);
        chk(wrap_o == 1'b0, "R8 wrap one cycle", 64'(wrap_o), 64'd0);
        set_cnt(64'h1_00000010);
        chk(fire_o == 1'b1, "R6 fire after wrap", 64'(fire_o), 64'd1);
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h5);
        set_cnt(64'h1_FFFFFFF0);
        set_cnt(64'h2_00000005);
        chk(wrap_o == 1'b0, "R8 no wrap in 64-bit", 64'(wrap_o), 64'd0);

        // R6 random reach decisions
        for (int t = 0; t < 60; t++) begin
            logic [63:0] c;
            logic [63:0] x;
            bit m32;
            bit e;
            m32 = (t >= 30);
            if (t == 0) wr(3'd0, 32'h0);
            if (t == 30) wr(3'd0, 32'h100);
            c = {$urandom, $urandom};
            if (m32) c[63:32] = 32'h0;
            count = c - 64'd1;
            wr(3'd2, c[31:0]);
            if (!m32) wr(3'd3, c[63:32]);
            @(negedge clk);
            if (t % 2 == 0) x = {$urandom, $urandom};
            else x = c + 64'(signed'($urandom_range(0, 16)) - 8);
            e = reached_fn(c, x, m32);
            set_cnt(x);
            chk(fire_o == e, "R6 random reach", 64'(fire_o), 64'(e));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule